// File: doc/BRIEF.md
# Disk-Bus Initiator Command and Interrupt Unit

This block is the byte-wide register file and command decoder of an initiator controller for a parallel disk bus. A host reaches sixteen byte registers on a 4-byte stride; the register index is the address field bits [5:2], brought in as a 4-bit port. The unit keeps the plain configuration registers and forms a 16-bit transfer count. It decodes opcodes written to the command register and updates the status, interrupt-cause and sequence-step registers. It drives a level interrupt and a matching DMA interrupt flag.

Selection commands take the target number from the last value written to the status register index (index 4). That register keeps no readable copy of the write. The unit checks the target against a present-devices mask. A plain selection with attention hands the command phase to outside logic through a request/acknowledge pair, and reports completion only after the acknowledge. Bus signalling, FIFO contents and data movement lie outside the block.

Top module: `dbc_cmd_unit`

## Requirements
- R1: After reset every register index reads 0x00 except index 14, which reads 0x04; `irq`, `dma_irq`, `cmd_req` and `dma_mode` are low.
- R2: Writes to indices 0, 1, 3, 8, 12, 13, 14 and 15 read back as written. A write to index 11 reads back ANDed with 0x15. Writes to indices 2, 4, 5, 6, 7, 9 and 10 leave their readable value unchanged.
- R3: `xfer_count` equals {index 1, index 0}. `dma_mode` equals bit 7 of the last byte written to index 3 (the command register, opcode in bits [6:0]).
- R4: Opcode 0x01 sets the interrupt-cause register (index 5) to 0x08 and the sequence step (index 6) to 0. It leaves status and `irq` unchanged.
- R5: Opcode 0x03 sets the interrupt-cause register to 0x80. It raises `irq` and `dma_irq` only when bit 6 of index 8 is clear.
- R6: Opcode 0x02 returns every register, `irq`, `dma_irq`, `cmd_req` and `dma_mode` to the R1 values, whatever bit 7 of the command byte holds.
- R7: Opcodes 0x42 and 0x43 use target = bits [2:0] of the last write to index 4. A target of 4 or more, or one whose `dev_present` bit is 0, gives status 0x80, interrupt cause 0x20 and sequence step 0, and raises `irq` and `dma_irq`.
- R8: Opcode 0x42 with a valid target raises `cmd_req` and drives `cmd_target`. The request is held until `cmd_ack`. On the cycle after `cmd_ack`, `cmd_req` is low, the interrupt cause is 0x18, the sequence step is 4 and `irq` is high.
- R9: Opcode 0x43 with a valid target sets status 0x92 (bit 7 interrupt, bit 4 terminal count, phase bits [2:0] = 2 command), interrupt cause 0x18 and sequence step 4. It raises `irq` at once and does not raise `cmd_req`.
- R10: A read of index 5 returns the current interrupt cause. From the next cycle the status keeps only bit 4, and `irq` and `dma_irq` are low; the interrupt cause itself is kept.
- R11: Any opcode other than 0x01, 0x02, 0x03, 0x42 and 0x43 leaves status, interrupt cause, sequence step, `irq` and `cmd_req` unchanged. Index 3 still shows the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 4 | Register index, address bits [5:2] |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| dev_present | input | 8 | One bit per target, 1 = device present |
| cmd_ack | input | 1 | Outside logic has completed the command phase |
| cmd_req | output | 1 | Selection with attention awaits the command phase |
| cmd_target | output | 3 | Target of the pending selection |
| irq | output | 1 | Interrupt line |
| dma_irq | output | 1 | DMA interrupt flag |
| dma_mode | output | 1 | DMA bit of the last command |
| xfer_count | output | 16 | Transfer count from indices 1 and 0 |

## Verification
The hardest state to reach is a pending selection that is still open when other traffic arrives. Here `cmd_req` must stay high through idle cycles, and a later chip reset must drop it. The bench reaches it by programming a present target, issuing opcode 0x42 and stalling `cmd_ack` for several cycles. It then either acknowledges or resets. The bench also leaves a selection's status at 0x92 before issuing unknown opcodes, so that an opcode which wrongly cleared state would show at the ports.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int DW    = 8;
  localparam int NREG  = 16;
  localparam int IDX_W = $clog2(NREG);

  localparam logic [IDX_W-1:0] IX_CMD  = 4'd3;
  localparam logic [IDX_W-1:0] IX_STAT = 4'd4;
  localparam logic [IDX_W-1:0] IX_INTR = 4'd5;
  localparam logic [IDX_W-1:0] IX_SEQ  = 4'd6;
  localparam logic [IDX_W-1:0] IX_CFG  = 4'd8;

  localparam logic [6:0] OP_FLUSH   = 7'h01;
  localparam logic [6:0] OP_CHIPRST = 7'h02;
  localparam logic [6:0] OP_BUSRST  = 7'h03;
  localparam logic [6:0] OP_SELATN  = 7'h42;
  localparam logic [6:0] OP_SELSTOP = 7'h43;

  localparam logic [DW-1:0] ST_INT   = 8'h80;
  localparam logic [DW-1:0] ST_TC    = 8'h10;
  localparam logic [DW-1:0] PH_CMD   = 8'h02;
  localparam logic [DW-1:0] IR_FC    = 8'h08;
  localparam logic [DW-1:0] IR_BS    = 8'h10;
  localparam logic [DW-1:0] IR_DC    = 8'h20;
  localparam logic [DW-1:0] IR_RST   = 8'h80;
  localparam logic [DW-1:0] SQ_CMD   = 8'h04;

  // Bits of a write that become readable at each plain index
  function automatic logic [DW-1:0] keep_mask(int i);
    case (i)
      0, 1, 3, 8, 12, 13, 14, 15: keep_mask = 8'hFF;
      11:                         keep_mask = 8'h15;
      default:                    keep_mask = 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] reset_value(int i);
    reset_value = (i == 14) ? 8'h04 : 8'h00;
  endfunction
endpackage

// File: rtl/dbc_regfile.sv
module dbc_regfile
  import dbc_pkg::*;
#(
  parameter int TGT_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [DW-1:0]             wr_data,
  input  logic                      soft_rst,
  output logic [NREG-1:0][DW-1:0]   plain_q,
  output logic [TGT_W-1:0]          target_q,
  output logic                      dma_mode_q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MASK = keep_mask(i);
    localparam logic [DW-1:0] RSTV = reset_value(i);
    if (MASK == '0) begin : g_const
      assign plain_q[i] = RSTV;
    end else begin : g_store
      logic          en;
      logic [DW-1:0] d;
      always_comb begin
        en = soft_rst || (wr_en && (wr_idx == IDX_W'(i)));
        d  = soft_rst ? RSTV : (wr_data & MASK);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  plain_q[i] <= RSTV;
        else if (en) plain_q[i] <= d;
      end
    end
  end

  logic             tgt_en, dma_en;
  logic [TGT_W-1:0] tgt_d;
  logic             dma_d;
  always_comb begin
    tgt_en = soft_rst || (wr_en && (wr_idx == IX_STAT));
    tgt_d  = soft_rst ? '0 : wr_data[TGT_W-1:0];
    dma_en = wr_en && (wr_idx == IX_CMD);
    dma_d  = soft_rst ? 1'b0 : wr_data[DW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q   <= '0;
      dma_mode_q <= 1'b0;
    end else begin
      if (tgt_en) target_q   <= tgt_d;
      if (dma_en) dma_mode_q <= dma_d;
    end
  end

  // R6
  soft_reset_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (plain_q[14] == 8'h04) && !dma_mode_q && (plain_q[0] == 8'h00));
  // R2
  masked_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd11 && !soft_rst) |=> (plain_q[11] & 8'hEA) == 8'h00);
endmodule

// File: rtl/dbc_cmd_ctl.sv
module dbc_cmd_ctl
  import dbc_pkg::*;
#(
  parameter int TGT_W   = 3,
  parameter int MAX_TGT = 4,
  localparam int NDEV   = 1 << TGT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [DW-1:0]    cmd_byte,
  input  logic             intr_rd,
  input  logic [TGT_W-1:0] target,
  input  logic             busrst_quiet,
  input  logic [NDEV-1:0]  dev_present,
  input  logic             cmd_ack,
  output logic [DW-1:0]    status_q,
  output logic [DW-1:0]    intr_q,
  output logic [DW-1:0]    seq_q,
  output logic             irq_q,
  output logic             dflag_q,
  output logic             pend_q,
  output logic [TGT_W-1:0] ptgt_q
);
  logic [6:0]       op;
  logic             tgt_ok, acked, en;
  logic [DW-1:0]    status_d, intr_d, seq_d;
  logic             irq_d, dflag_d, pend_d;
  logic [TGT_W-1:0] ptgt_d;

  assign op     = cmd_byte[6:0];
  assign tgt_ok = (int'(target) < MAX_TGT) && dev_present[target];
  assign acked  = pend_q && cmd_ack;
  assign en     = cmd_we || intr_rd || acked;

  always_comb begin
    status_d = status_q;
    intr_d   = intr_q;
    seq_d    = seq_q;
    irq_d    = irq_q;
    dflag_d  = dflag_q;
    pend_d   = pend_q;
    ptgt_d   = ptgt_q;
    if (intr_rd) begin
      status_d = status_q & ST_TC;
      irq_d    = 1'b0;
      dflag_d  = 1'b0;
    end
    if (acked) begin
      intr_d  = IR_BS | IR_FC;
      seq_d   = SQ_CMD;
      irq_d   = 1'b1;
      dflag_d = 1'b1;
      pend_d  = 1'b0;
    end
    if (cmd_we) begin
      case (op)
        OP_FLUSH: begin
          intr_d = IR_FC;
          seq_d  = '0;
        end
        OP_CHIPRST: begin
          status_d = '0;
          intr_d   = '0;
          seq_d    = '0;
          irq_d    = 1'b0;
          dflag_d  = 1'b0;
          pend_d   = 1'b0;
          ptgt_d   = '0;
        end
        OP_BUSRST: begin
          intr_d = IR_RST;
          if (!busrst_quiet) begin
            irq_d   = 1'b1;
            dflag_d = 1'b1;
          end
        end
        OP_SELATN, OP_SELSTOP: begin
          if (!tgt_ok) begin
            status_d = ST_INT;
            intr_d   = IR_DC;
            seq_d    = '0;
            irq_d    = 1'b1;
            dflag_d  = 1'b1;
          end else if (op == OP_SELATN) begin
            pend_d = 1'b1;
            ptgt_d = target;
          end else begin
            status_d = ST_INT | ST_TC | PH_CMD;
            intr_d   = IR_BS | IR_FC;
            seq_d    = SQ_CMD;
            irq_d    = 1'b1;
            dflag_d  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      intr_q   <= '0;
      seq_q    <= '0;
      irq_q    <= 1'b0;
      dflag_q  <= 1'b0;
      pend_q   <= 1'b0;
      ptgt_q   <= '0;
    end else if (en) begin
      status_q <= status_d;
      intr_q   <= intr_d;
      seq_q    <= seq_d;
      irq_q    <= irq_d;
      dflag_q  <= dflag_d;
      pend_q   <= pend_d;
      ptgt_q   <= ptgt_d;
    end
  end

  // R10
  intr_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_rd && !cmd_we && !acked) |=> !irq_q && !dflag_q && ((status_q & 8'hEF) == 8'h00));
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cmd_ack && !cmd_we) |=> pend_q);
  // R8
  ack_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acked && !cmd_we) |=> irq_q && !pend_q && (seq_q == 8'h04) && (intr_q == 8'h18));
  // R11
  unknown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !intr_rd && !acked && op != OP_FLUSH && op != OP_CHIPRST &&
     op != OP_BUSRST && op != OP_SELATN && op != OP_SELSTOP)
    |=> $stable(status_q) && $stable(intr_q) && $stable(seq_q) && $stable(irq_q) && $stable(pend_q));
  // R5
  quiet_busrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && op == OP_BUSRST && busrst_quiet && !irq_q && !acked) |=> !irq_q);
endmodule

// File: rtl/dbc_cmd_unit.sv
module dbc_cmd_unit
  import dbc_pkg::*;
#(
  parameter int TGT_W   = 3,
  parameter int MAX_TGT = 4,
  localparam int NDEV   = 1 << TGT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [5:2]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NDEV-1:0]  dev_present,
  input  logic             cmd_ack,
  output logic             cmd_req,
  output logic [TGT_W-1:0] cmd_target,
  output logic             irq,
  output logic             dma_irq,
  output logic             dma_mode,
  output logic [2*DW-1:0]  xfer_count
);
  logic [IDX_W-1:0]        idx;
  logic                    cmd_we, intr_rd, soft_rst;
  logic [NREG-1:0][DW-1:0] plain_q;
  logic [TGT_W-1:0]        target_q;
  logic [DW-1:0]           status_q, intr_q, seq_q;

  assign idx      = reg_addr;
  assign cmd_we   = reg_wr && (idx == IX_CMD);
  assign intr_rd  = reg_rd && (idx == IX_INTR);
  assign soft_rst = cmd_we && (reg_wdata[6:0] == OP_CHIPRST);

  dbc_regfile #(.TGT_W(TGT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .wr_idx     (idx),
    .wr_data    (reg_wdata),
    .soft_rst   (soft_rst),
    .plain_q    (plain_q),
    .target_q   (target_q),
    .dma_mode_q (dma_mode)
  );

  dbc_cmd_ctl #(.TGT_W(TGT_W), .MAX_TGT(MAX_TGT)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_we       (cmd_we),
    .cmd_byte     (reg_wdata),
    .intr_rd      (intr_rd),
    .target       (target_q),
    .busrst_quiet (plain_q[IX_CFG][6]),
    .dev_present  (dev_present),
    .cmd_ack      (cmd_ack),
    .status_q     (status_q),
    .intr_q       (intr_q),
    .seq_q        (seq_q),
    .irq_q        (irq),
    .dflag_q      (dma_irq),
    .pend_q       (cmd_req),
    .ptgt_q       (cmd_target)
  );

  always_comb begin
    case (idx)
      IX_STAT: reg_rdata = status_q;
      IX_INTR: reg_rdata = intr_q;
      IX_SEQ:  reg_rdata = seq_q;
      default: reg_rdata = plain_q[idx];
    endcase
  end

  assign xfer_count = {plain_q[1], plain_q[0]};

  // R1
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> dma_irq);
  // R6
  chip_reset_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !irq && !cmd_req && (reg_addr != IX_STAT || reg_rdata == 8'h00));
endmodule

// File: tb/tb_dbc_cmd_unit.sv
`timescale 1ns/1ps
module tb_dbc_cmd_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, cmd_ack;
  logic [5:2]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata, dev_present;
  logic        cmd_req, irq, dma_irq, dma_mode;
  logic [2:0]  cmd_target;
  logic [15:0] xfer_count;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_reg [16];
  logic [7:0] rv;

  always #10 clk = ~clk;

  dbc_cmd_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_present(dev_present), .cmd_ack(cmd_ack), .cmd_req(cmd_req),
    .cmd_target(cmd_target), .irq(irq), .dma_irq(dma_irq),
    .dma_mode(dma_mode), .xfer_count(xfer_count)
  );

  function automatic logic [7:0] kept(int i, logic [7:0] v);
    case (i)
      0, 1, 3, 8, 12, 13, 14, 15: kept = v;
      11:                         kept = v & 8'h15;
      default:                    kept = 8'hxx;
    endcase
  endfunction

  function automatic logic stores(int i);
    stores = (i == 0 || i == 1 || i == 3 || i == 8 || i == 11 || i >= 12);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int i, logic [7:0] v);
    @(negedge clk);
    reg_addr = 4'(i); reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int i, output logic [7:0] v);
    @(negedge clk);
    reg_addr = 4'(i); reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic reset_values(string tag);
    for (int i = 0; i < 16; i++) begin
      rd(i, rv);
      chk(tag, rv, (i == 14) ? 8'h04 : 8'h00);
    end
    chk(tag, {irq, dma_irq, cmd_req, dma_mode}, 4'b0000);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; cmd_ack = 0;
    reg_addr = '0; reg_wdata = '0; dev_present = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    reset_values("R1 reset");

    for (int i = 0; i < 16; i++) exp_reg[i] = (i == 14) ? 8'h04 : 8'h00;
    for (int k = 0; k < 80; k++) begin
      int i;
      logic [7:0] v;
      i = int'($urandom_range(15, 0));
      if (i == 3) i = 12;
      v = 8'($urandom);
      wr(i, v);
      if (stores(i)) exp_reg[i] = kept(i, v);
      rd(i, rv);
      chk("R2 readback", rv, exp_reg[i]);
    end
    chk("R3 xfer_count", xfer_count, {exp_reg[1], exp_reg[0]});
    wr(0, 8'h34); wr(1, 8'h12);
    chk("R3 xfer_count directed", xfer_count, 16'h1234);
    wr(11, 8'hFF); rd(11, rv); chk("R2 mask 11", rv, 8'h15);
    wr(9, 8'hA5);  rd(9, rv);  chk("R2 idx9 ignored", rv, 8'h00);
    wr(8, 8'h00);

    // bus reset, interrupt enabled
    wr(3, 8'h03);
    chk("R5 irq raised", {irq, dma_irq}, 2'b11);
    rd(5, rv); chk("R5 cause", rv, 8'h80);
    chk("R10 irq cleared", {irq, dma_irq}, 2'b00);
    rd(5, rv); chk("R10 cause kept", rv, 8'h80);
    // bus reset, suppressed
    wr(8, 8'h40); wr(3, 8'h03);
    chk("R5 suppressed", {irq, dma_irq}, 2'b00);
    wr(8, 8'h00);

    // select-and-stop to present target 2 with DMA bit
    dev_present = 8'b0000_0100;
    wr(4, 8'hFA);
    wr(3, 8'hC3);
    chk("R3 dma_mode set", dma_mode, 1'b1);
    chk("R9 irq", {irq, dma_irq, cmd_req}, 3'b110);
    rd(4, rv); chk("R9 status", rv, 8'h92);
    rd(6, rv); chk("R9 seq", rv, 8'h04);
    rd(5, rv); chk("R9 cause", rv, 8'h18);
    rd(4, rv); chk("R10 status keeps tc", rv, 8'h10);

    // flush moves seq 4 -> 0, status untouched
    wr(3, 8'h01);
    rd(6, rv); chk("R4 seq", rv, 8'h00);
    rd(4, rv); chk("R4 status kept", rv, 8'h10);
    chk("R4 irq kept", irq, 1'b0);
    rd(5, rv); chk("R4 cause", rv, 8'h08);

    // absent target
    wr(4, 8'h01); wr(3, 8'h42);
    chk("R3 dma_mode clear", dma_mode, 1'b0);
    chk("R7 absent irq", {irq, dma_irq, cmd_req}, 3'b110);
    rd(4, rv); chk("R7 absent status", rv, 8'h80);
    rd(6, rv); chk("R7 absent seq", rv, 8'h00);
    rd(5, rv); chk("R7 absent cause", rv, 8'h20);
    // out of range target, all present
    dev_present = 8'hFF;
    wr(4, 8'h05); wr(3, 8'h43);
    rd(4, rv); chk("R7 range status", rv, 8'h80);
    rd(5, rv); chk("R7 range cause", rv, 8'h20);

    // select with attention, stalled handshake
    wr(4, 8'h03); wr(3, 8'h42);
    chk("R8 request", {cmd_req, cmd_target, irq}, {1'b1, 3'd3, 1'b0});
    repeat (4) @(negedge clk);
    chk("R8 held", cmd_req, 1'b1);
    cmd_ack = 1'b1; @(negedge clk); cmd_ack = 1'b0;
    chk("R8 done", {cmd_req, irq, dma_irq}, 3'b011);
    rd(6, rv); chk("R8 seq", rv, 8'h04);
    rd(5, rv); chk("R8 cause", rv, 8'h18);

    // unknown opcodes keep state
    wr(3, 8'h43);
    for (int k = 0; k < 6; k++) begin
      logic [6:0] op;
      op = 7'($urandom);
      if (op == 7'h01 || op == 7'h02 || op == 7'h03 || op == 7'h42 || op == 7'h43)
        op = op ^ 7'h20;
      wr(3, {1'b0, op});
      chk("R11 irq", {irq, cmd_req}, 2'b10);
      rd(4, rv); chk("R11 status", rv, 8'h92);
      rd(6, rv); chk("R11 seq", rv, 8'h04);
      rd(3, rv); chk("R11 cmd readback", rv, {1'b0, op});
    end

    // chip reset with a pending selection and irq high
    wr(3, 8'h42);
    chk("R8 pending before reset", {cmd_req, irq}, 2'b11);
    wr(3, 8'h82);
    reset_values("R6 chip reset");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule